// File: doc/BRIEF.md
# Multi-Queue FIFO Manager with Watermark Status

This block keeps sixty-four independent FIFOs of 32-bit entries in one shared buffer RAM, behind a word-addressed register bus. The bus has a separate write channel and read channel. Each queue has four consecutive bus words that act as its access window. Writing any of those words pushes an entry, and reading any of them pops the oldest entry. Read data appears in the cycle after the read request.

Software loads a configuration word for each queue. The word sets where the queue's storage starts in the buffer RAM, the queue length as a power of two, and two 3-bit watermark codes. Status is packed into a small block of bus words placed right after the access windows:

- The lower half of the queue space (queues 0 to 31) reports four level flags per queue.
- The lower half also keeps sticky underflow and overflow bits, which clear when their word is read.
- The upper half (queues 32 to 63) reports only a nearly-empty bit and a full bit per queue.

Top module: `qmgr_top`

## Requirements
- R1: After reset every queue is empty, with length 1, both watermark codes 0 and base 0. Status reads at that point give:
  - 0x33333333 from each of words 0x100 to 0x103;
  - 0 from words 0x104 and 0x105;
  - 0xFFFFFFFF from word 0x106;
  - 0 from word 0x107.
- R2: A write to word 0x800+q configures queue q and leaves it empty. The configuration word has these fields:
  - bits [9:0]: base slot in the buffer RAM;
  - bits [22:20]: log2 of the length, where any value above 6 means 64;
  - bits [26:24]: low watermark code;
  - bits [30:28]: high watermark code.
- R3: A write to any of words 4q to 4q+3 pushes the data onto queue q. A read of any of those words pops the oldest entry, which appears on rd_data one cycle later. Entries come out in first-in, first-out order, including when the storage index wraps at the queue length.
- R4: A pop from an empty queue returns 0 and changes nothing else in the queue. A push to a full queue is dropped and leaves the stored entries unchanged.
- R5: A watermark code c stands for 0 entries when c is 0, and for 2^(c-1) entries when c is 1 to 7.
- R6: The four level flags are defined as follows:
  - empty: the fill level is 0;
  - full: the fill level equals the length;
  - nearly empty: the fill level is at or below the low watermark;
  - nearly full: the free space is at or below the high watermark.
- R7: Status word 0x100+(q/8), for q below 32, holds queue q's flags at bits 4*(q%8) and up. Within that nibble, bit 0 is empty, bit 1 is nearly empty, bit 2 is nearly full and bit 3 is full.
- R8: Status word 0x104+(q/16), for q below 32, holds underflow at bit 2*(q%16) and overflow at bit 2*(q%16)+1.
  - These bits are set by a pop on an empty queue or a push on a full queue.
  - Reading the word returns its current value and then clears it.
  - An event in the same cycle as that read is not in the returned word but stays set afterwards.
- R9: For queues 32 to 63, bit q-32 of word 0x106 is nearly empty and bit q-32 of word 0x107 is full. Underflow and overflow on these queues change no status word.
- R10: A push and a pop on the same queue in one cycle are judged on the fill level before that cycle:
  - on a non-empty, non-full queue both take effect;
  - on an empty queue the pop returns 0 and sets underflow, and the push is stored;
  - on a full queue the push is dropped and sets overflow, and the pop is served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 12 | Write word address |
| wr_data | input | 32 | Write data (queue entry or configuration word) |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read word address |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |

## Verification
Because the read and write channels are independent, two pairs of functions can fall in the same cycle.

- Recording an overflow can coincide with the read-and-clear of the status word that holds it. The bench pushes onto a full single-entry queue in the same cycle that it reads that word. It then expects the old value on rd_data and finds the overflow bit still set on the next read.
- A push and a pop can hit the same queue at once. The bench provokes this on a partly filled queue, an empty queue and a full queue. It judges each case against a model that applies the pre-cycle fill level to both halves.

// File: rtl/qm_pkg.sv
package qm_pkg;
  // Field positions inside a queue configuration word
  localparam int CFG_LEN_LSB = 20;
  localparam int CFG_LO_LSB  = 24;
  localparam int CFG_HI_LSB  = 28;

  // 3-bit watermark code to entry count: 0 -> 0, c -> 2^(c-1)
  function automatic logic [7:0] wm_decode(input logic [2:0] code);
    wm_decode = (code == 3'd0) ? 8'd0 : (8'd1 << (code - 3'd1));
  endfunction
endpackage

// File: rtl/qm_buf_ram.sv
module qm_buf_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rd <= mem[ra];
  end
endmodule

// File: rtl/qm_queue_ctrl.sv
module qm_queue_ctrl import qm_pkg::*; #(
  parameter int PW     = 6,
  parameter int BAW    = 10,
  parameter bit STICKY = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic           pop,
  input  logic           cfg_we,
  input  logic [31:0]    cfg_word,
  input  logic           clr_sticky,
  output logic [BAW-1:0] waddr,
  output logic [BAW-1:0] raddr,
  output logic           empty,
  output logic           nempty,
  output logic           nfull,
  output logic           full,
  output logic           uflow,
  output logic           oflow
);
  localparam int CW = PW + 1;

  logic [BAW-1:0] base;
  logic [2:0]     len_log, lo_code, hi_code;
  logic [PW-1:0]  wp, rp, mask;
  logic [CW-1:0]  cnt, len;
  logic [7:0]     free8;
  logic           push_ok, pop_ok;
  logic           unused_cfg;

  assign unused_cfg = ^cfg_word;

  always_comb begin
    len     = (len_log > 3'(PW)) ? (CW'(1) << PW) : (CW'(1) << len_log);
    mask    = PW'(len - CW'(1));
    empty   = (cnt == '0);
    full    = (cnt == len);
    free8   = 8'(len - cnt);
    nempty  = 8'(cnt) <= wm_decode(lo_code);
    nfull   = free8 <= wm_decode(hi_code);
    push_ok = push & ~full;
    pop_ok  = pop & ~empty;
    waddr   = base + BAW'(wp);
    raddr   = base + BAW'(rp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base    <= '0;
      len_log <= '0;
      lo_code <= '0;
      hi_code <= '0;
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
    end else if (cfg_we) begin
      base    <= cfg_word[BAW-1:0];
      len_log <= cfg_word[CFG_LEN_LSB +: 3];
      lo_code <= cfg_word[CFG_LO_LSB +: 3];
      hi_code <= cfg_word[CFG_HI_LSB +: 3];
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
    end else begin
      if (push_ok) wp <= (wp + PW'(1)) & mask;
      if (pop_ok)  rp <= (rp + PW'(1)) & mask;
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  generate
    if (STICKY) begin : g_sticky
      logic uf_q, of_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          uf_q <= 1'b0;
          of_q <= 1'b0;
        end else begin
          uf_q <= (pop & empty) | (uf_q & ~clr_sticky);
          of_q <= (push & full) | (of_q & ~clr_sticky);
        end
      end
      assign uflow = uf_q;
      assign oflow = of_q;
    end else begin : g_none
      logic unused_clr;
      assign unused_clr = clr_sticky;
      assign uflow = 1'b0;
      assign oflow = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/qm_status_pack.sv
module qm_status_pack #(
  parameter int NQ   = 64,
  parameter int SELW = 3
) (
  input  logic [NQ-1:0]   empty,
  input  logic [NQ-1:0]   nempty,
  input  logic [NQ-1:0]   nfull,
  input  logic [NQ-1:0]   full,
  input  logic [NQ/2-1:0] uflow,
  input  logic [NQ/2-1:0] oflow,
  input  logic [SELW-1:0] sel,
  output logic [31:0]     word
);
  localparam int LH  = NQ / 2;
  localparam int S1W = LH / 8;
  localparam int S2W = LH / 16;

  logic [LH*4-1:0] s1_flat;
  logic [LH*2-1:0] s2_flat;
  int              idx;

  always_comb begin
    for (int i = 0; i < LH; i++) begin
      s1_flat[i*4 +: 4] = {full[i], nfull[i], nempty[i], empty[i]};
      s2_flat[i*2 +: 2] = {oflow[i], uflow[i]};
    end
  end

  always_comb begin
    idx  = int'(sel);
    word = '0;
    if (idx < S1W)
      word = s1_flat[idx*32 +: 32];
    else if (idx < S1W + S2W)
      word = s2_flat[(idx-S1W)*32 +: 32];
    else if (idx == S1W + S2W)
      word = 32'(nempty[NQ-1:LH]);
    else if (idx == S1W + S2W + 1)
      word = 32'(full[NQ-1:LH]);
  end
endmodule

// File: rtl/qmgr_top.sv
module qmgr_top import qm_pkg::*; #(
  parameter int NQ  = 64,
  parameter int DW  = 32,
  parameter int AW  = 12,
  parameter int BAW = 10,
  parameter int PW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int QW       = $clog2(NQ);
  localparam int LH       = NQ / 2;
  localparam int WIN_WDS  = NQ * 4;
  localparam int ST_BASE  = WIN_WDS;
  localparam int ST_WDS   = LH/8 + LH/16 + 2;
  localparam int SELW     = $clog2(ST_WDS);
  localparam int S2_FIRST = LH / 8;
  localparam int CFG_BASE = 2048;

  logic          wr_win, wr_cfg, rd_win, rd_st;
  logic [QW-1:0] wq, rq, cq;
  logic [SELW-1:0] ssel;
  logic [NQ-1:0] push_req, pop_req, cfg_req, clr_req;
  logic [NQ-1:0] q_empty, q_nempty, q_nfull, q_full;
  logic [LH-1:0] uf_lo, of_lo;
  logic [BAW-1:0] waddr_a [NQ];
  logic [BAW-1:0] raddr_a [NQ];
  logic [31:0]   st_word, stat_q;
  logic [DW-1:0] ram_q;
  logic          rsel_ram, ram_we, ram_re;

  always_comb begin
    wr_win = wr_en && (int'(wr_addr) < WIN_WDS);
    wr_cfg = wr_en && (int'(wr_addr) >= CFG_BASE) && (int'(wr_addr) < CFG_BASE + NQ);
    rd_win = rd_en && (int'(rd_addr) < WIN_WDS);
    rd_st  = rd_en && (int'(rd_addr) >= ST_BASE) && (int'(rd_addr) < ST_BASE + ST_WDS);
    wq     = wr_addr[QW+1:2];
    rq     = rd_addr[QW+1:2];
    cq     = QW'(int'(wr_addr) - CFG_BASE);
    ssel   = SELW'(int'(rd_addr) - ST_BASE);
    for (int i = 0; i < NQ; i++) begin
      push_req[i] = wr_win && (wq == QW'(i));
      pop_req[i]  = rd_win && (rq == QW'(i));
      cfg_req[i]  = wr_cfg && (cq == QW'(i));
      clr_req[i]  = (i < LH) && rd_st && (int'(ssel) == S2_FIRST + i/16);
    end
  end

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_q
      if (g < LH) begin : g_lo
        qm_queue_ctrl #(.PW(PW), .BAW(BAW), .STICKY(1'b1)) u_ctrl (
          .clk(clk), .rst(rst), .push(push_req[g]), .pop(pop_req[g]),
          .cfg_we(cfg_req[g]), .cfg_word(wr_data), .clr_sticky(clr_req[g]),
          .waddr(waddr_a[g]), .raddr(raddr_a[g]),
          .empty(q_empty[g]), .nempty(q_nempty[g]), .nfull(q_nfull[g]), .full(q_full[g]),
          .uflow(uf_lo[g]), .oflow(of_lo[g]));
      end else begin : g_hi
        logic unused_uf, unused_of;
        qm_queue_ctrl #(.PW(PW), .BAW(BAW), .STICKY(1'b0)) u_ctrl (
          .clk(clk), .rst(rst), .push(push_req[g]), .pop(pop_req[g]),
          .cfg_we(cfg_req[g]), .cfg_word(wr_data), .clr_sticky(clr_req[g]),
          .waddr(waddr_a[g]), .raddr(raddr_a[g]),
          .empty(q_empty[g]), .nempty(q_nempty[g]), .nfull(q_nfull[g]), .full(q_full[g]),
          .uflow(unused_uf), .oflow(unused_of));
      end
    end
  endgenerate

  assign ram_we = wr_win && !q_full[wq];
  assign ram_re = rd_win && !q_empty[rq];

  qm_buf_ram #(.AW(BAW), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .wa(waddr_a[wq]), .wd(wr_data),
    .re(ram_re), .ra(raddr_a[rq]), .rd(ram_q));

  qm_status_pack #(.NQ(NQ), .SELW(SELW)) u_pack (
    .empty(q_empty), .nempty(q_nempty), .nfull(q_nfull), .full(q_full),
    .uflow(uf_lo), .oflow(of_lo), .sel(ssel), .word(st_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_ram <= 1'b0;
      stat_q   <= '0;
    end else begin
      rsel_ram <= ram_re;
      stat_q   <= rd_st ? st_word : '0;
    end
  end

  assign rd_data = rsel_ram ? ram_q : DW'(stat_q);
endmodule

// File: rtl/qmgr_top_chk.sv
module qmgr_top_chk #(
  parameter int NQ = 64,
  parameter int QW = 6
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     rd_data,
  input logic [NQ-1:0]   push_req,
  input logic [NQ-1:0]   pop_req,
  input logic [NQ-1:0]   cfg_req,
  input logic [NQ-1:0]   q_empty,
  input logic [NQ-1:0]   q_full,
  input logic [NQ/2-1:0] uf_lo,
  input logic [NQ/2-1:0] of_lo,
  input logic            rd_win,
  input logic [QW-1:0]   rq
);
  // R4
  underflow_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_win && q_empty[rq]) |=> (rd_data == 32'd0));

  generate
    for (genvar i = 0; i < NQ; i++) begin : g_all
      // R6
      empty_full_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(q_empty[i] && q_full[i]));
      // R4
      drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req[i] && q_full[i] && !pop_req[i] && !cfg_req[i]) |=> q_full[i]);
    end
    for (genvar i = 0; i < NQ/2; i++) begin : g_lo
      // R8
      uflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req[i] && q_empty[i]) |=> uf_lo[i]);
      // R8
      oflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req[i] && q_full[i]) |=> of_lo[i]);
    end
  endgenerate
endmodule

bind qmgr_top qmgr_top_chk #(.NQ(NQ), .QW(QW)) u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .push_req(push_req), .pop_req(pop_req),
  .cfg_req(cfg_req), .q_empty(q_empty), .q_full(q_full), .uf_lo(uf_lo),
  .of_lo(of_lo), .rd_win(rd_win), .rq(rq));

// File: tb/test_qmgr_top.sv
module test_qmgr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  qmgr_top i_qmgr_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  int n_chk = 0, n_err = 0;
  int m_cnt[64], m_len[64], m_lo[64], m_hi[64], m_head[64];
  logic [31:0] m_dat[64][64];
  bit m_uf[32], m_of[32];

  function automatic int wmv(int c);
    return (c == 0) ? 0 : (1 << (c - 1));
  endfunction

  function automatic logic [3:0] nib(int q);
    return {m_cnt[q] == m_len[q], (m_len[q] - m_cnt[q]) <= wmv(m_hi[q]),
            m_cnt[q] <= wmv(m_lo[q]), m_cnt[q] == 0};
  endfunction

  function automatic logic [31:0] e_word(int w);
    logic [31:0] r;
    r = '0;
    if (w < 4) for (int k = 0; k < 8; k++) r[k*4 +: 4] = nib(w*8 + k);
    else if (w < 6) for (int k = 0; k < 16; k++) r[k*2 +: 2] = {m_of[(w-4)*16+k], m_uf[(w-4)*16+k]};
    else if (w == 6) for (int k = 0; k < 32; k++) r[k] = m_cnt[32+k] <= wmv(m_lo[32+k]);
    else for (int k = 0; k < 32; k++) r[k] = m_cnt[32+k] == m_len[32+k];
    return r;
  endfunction

  function automatic void mdl_push(int q, logic [31:0] d);
    if (m_cnt[q] == m_len[q]) begin
      if (q < 32) m_of[q] = 1'b1;
    end else begin
      m_dat[q][(m_head[q] + m_cnt[q]) % m_len[q]] = d;
      m_cnt[q]++;
    end
  endfunction

  function automatic logic [31:0] mdl_pop(int q);
    logic [31:0] r;
    r = '0;
    if (m_cnt[q] == 0) begin
      if (q < 32) m_uf[q] = 1'b1;
    end else begin
      r = m_dat[q][m_head[q]];
      m_head[q] = (m_head[q] + 1) % m_len[q];
      m_cnt[q]--;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic we, input int wa, input logic [31:0] wd,
                     input logic re, input int ra, output logic [31:0] rv);
    @(negedge clk);
    wr_en = we; wr_addr = 12'(wa); wr_data = wd;
    rd_en = re; rd_addr = 12'(ra);
    @(negedge clk);
    rv = rd_data;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic cfg(input int q, input int base, input int lg, input int lo, input int hi);
    logic [31:0] v;
    bus(1'b1, 2048 + q, 32'(base) | (32'(lg) << 20) | (32'(lo) << 24) | (32'(hi) << 28), 1'b0, 0, v);
    m_len[q] = 1 << ((lg > 6) ? 6 : lg);
    m_lo[q] = lo; m_hi[q] = hi; m_cnt[q] = 0; m_head[q] = 0;
  endtask

  task automatic push(input int q, input logic [31:0] d);
    logic [31:0] v;
    bus(1'b1, q*4 + int'(d[1:0]), d, 1'b0, 0, v);
    mdl_push(q, d);
  endtask

  task automatic pop(input int q, input string tag);
    logic [31:0] v, e;
    bus(1'b0, 0, 0, 1'b1, q*4 + 3, v);
    e = mdl_pop(q);
    chk(tag, v, e);
  endtask

  task automatic clear_model(input int w);
    if (w == 4 || w == 5)
      for (int k = 0; k < 16; k++) begin
        m_uf[(w-4)*16+k] = 1'b0;
        m_of[(w-4)*16+k] = 1'b0;
      end
  endtask

  task automatic rd_stat(input int w, input string tag);
    logic [31:0] v, e;
    e = e_word(w);
    bus(1'b0, 0, 0, 1'b1, 256 + w, v);
    chk(tag, v, e);
    clear_model(w);
  endtask

  task automatic both(input int q, input logic [31:0] d, input string tag);
    logic [31:0] v, e;
    bit f, em;
    f = (m_cnt[q] == m_len[q]);
    em = (m_cnt[q] == 0);
    bus(1'b1, q*4, d, 1'b1, q*4 + 1, v);
    e = '0;
    if (em) begin
      if (q < 32) m_uf[q] = 1'b1;
    end else e = mdl_pop(q);
    if (f) begin
      if (q < 32) m_of[q] = 1'b1;
    end else mdl_push(q, d);
    chk(tag, v, e);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog R3: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, e;
    for (int q = 0; q < 64; q++) begin
      m_cnt[q] = 0; m_len[q] = 1; m_lo[q] = 0; m_hi[q] = 0; m_head[q] = 0;
    end
    for (int q = 0; q < 32; q++) begin m_uf[q] = 1'b0; m_of[q] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset image of every status word
    for (int w = 0; w < 8; w++) rd_stat(w, "R1 reset status");

    // R5 R6 R7: every watermark code against every fill level of a 64-entry queue
    for (int c = 0; c < 8; c++) begin
      cfg(2, 0, 6, c, 7 - c);
      for (int n = 0; n <= 64; n++) begin
        rd_stat(0, "R5 R6 R7 flag sweep");
        push(2, 32'(c * 1000 + n));
      end
    end
    // R3 R4: contents intact after dropped push, then underflow
    for (int n = 0; n < 64; n++) pop(2, "R3 fifo order");
    pop(2, "R4 empty pop zero");
    rd_stat(4, "R8 sticky read");
    rd_stat(4, "R8 sticky cleared");

    // R3: pointer wrap on a 4-entry queue
    cfg(9, 300, 2, 1, 1);
    for (int it = 0; it < 20; it++) begin
      for (int k = 0; k < 3; k++) push(9, 32'(it * 16 + k + 5));
      rd_stat(1, "R3 R7 wrap status");
      for (int k = 0; k < 3; k++) pop(9, "R3 wrap order");
    end

    // R9: upper-half queue
    cfg(45, 500, 3, 3, 0);
    for (int n = 0; n <= 9; n++) begin
      rd_stat(6, "R9 upper nearly empty");
      rd_stat(7, "R9 upper full");
      push(45, 32'(7000 + n));
    end
    rd_stat(4, "R9 no sticky low word");
    rd_stat(5, "R9 no sticky high word");
    for (int n = 0; n < 9; n++) pop(45, "R9 upper pop");
    rd_stat(5, "R9 no sticky after underflow");

    // R10: same-cycle push and pop
    cfg(9, 300, 2, 1, 1);
    push(9, 32'h111); push(9, 32'h222);
    both(9, 32'h333, "R10 both partial");
    rd_stat(1, "R10 level unchanged");
    pop(9, "R10 order"); pop(9, "R10 order");
    both(9, 32'h444, "R10 both on empty");
    rd_stat(4, "R10 underflow flagged");
    pop(9, "R10 push kept on empty");
    for (int k = 0; k < 4; k++) push(9, 32'(32'h500 + k));
    both(9, 32'h5FF, "R10 both on full");
    rd_stat(4, "R10 overflow flagged");
    for (int k = 0; k < 4; k++) pop(9, "R10 full drop order");

    // R2: reconfiguration empties; oversized length code means 64
    push(9, 32'h9A); push(9, 32'h9B);
    cfg(9, 300, 2, 1, 1);
    rd_stat(1, "R2 reconfig empties");
    cfg(11, 600, 7, 0, 0);
    for (int n = 0; n < 64; n++) push(11, 32'(n));
    rd_stat(1, "R2 length clamp full");
    pop(11, "R2 clamp data");

    // R8: overflow in the same cycle as reading its word
    rd_stat(4, "R8 pre-clear");
    cfg(7, 900, 0, 0, 0);
    push(7, 32'hABC);
    e = e_word(4);
    bus(1'b1, 7*4, 32'hDEF, 1'b1, 260, v);
    chk("R8 same-cycle read value", v, e);
    clear_model(4);
    mdl_push(7, 32'hDEF);
    rd_stat(4, "R8 same-cycle event kept");
    rd_stat(4, "R8 cleared after read");
    pop(7, "R8 data kept");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule